// File: doc/BRIEF.md
# Three-Bit-Coded Arithmetic and Logic Unit

This block is a purely combinational datapath unit. It takes two operand words and a three-bit function code, and it returns one result word and a flag that marks a result of all zeros. It is meant to sit between a register read stage and a write-back or address stage. The result appears in the same cycle that the inputs are presented.

The function code has two fields. The top bit selects the complemented second operand and also supplies the carry into a single shared adder, so one adder serves both addition and subtraction. The same conditioned operand also feeds the bitwise AND and OR units. The two low bits pick the output source:

- the AND unit,
- the OR unit,
- the adder sum,
- the sign bit of the sum, widened with zeros (the set-if-less result).

The set-if-less result takes the raw sign of the difference. It does not correct for signed overflow. Code `011` is reserved and drives a zero result.

Top module: `alu3_core`

## Requirements
- R1: With `func` = 3'b000, `y_out` equals `a_in & b_in`.
- R2: With `func` = 3'b001, `y_out` equals `a_in | b_in`.
- R3: With `func` = 3'b010, `y_out` equals `a_in + b_in` modulo 2^32; the carry out is discarded.
- R4: With `func` = 3'b100, `y_out` equals `a_in & ~b_in`.
- R5: With `func` = 3'b101, `y_out` equals `a_in | ~b_in`.
- R6: With `func` = 3'b110, `y_out` equals `a_in - b_in` modulo 2^32, formed as `a_in + ~b_in + 1`.
- R7: With `func` = 3'b111, `y_out[0]` is bit 31 of `a_in - b_in` and bits 31..1 are zero. Signed overflow is not corrected. For example, 0x7FFFFFFF with 0xFFFFFFFF gives 1, and 0x80000000 with 0x00000001 gives 0.
- R8: With the reserved code `func` = 3'b011, `y_out` is all zeros whatever the operands are.
- R9: `zero_out` is 1 exactly when all 32 bits of `y_out` are 0.
- R10: Both outputs depend only on the present inputs. There is no storage, and a new input set is reflected within the same clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand, complemented when `func[2]` is 1 |
| func | input | 3 | Function code: bit 2 selects invert and carry-in, bits 1..0 select the output source |
| y_out | output | 32 | Result word |
| zero_out | output | 1 | High when `y_out` is all zeros |

## Verification
Every result and the zero flag are due zero cycles after the stimulus, because no register lies between the ports. The bench applies each operand set on a falling clock edge and reads both outputs a quarter period later, before the next rising edge. A stale or registered result is therefore caught as a mismatch. A directed table covers the overflow cases of the set-if-less result and the reserved code. A pseudo-random sweep then compares all eight codes against a model that the bench computes from the requirements.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

    localparam int unsigned FUNC_W = 3;

    // low two bits of the function code: output source
    typedef enum logic [1:0] {
        SRC_AND = 2'b00,
        SRC_OR  = 2'b01,
        SRC_SUM = 2'b10,
        SRC_LT  = 2'b11
    } src_sel_e;

    // the one code that is not allocated to a function
    localparam logic [FUNC_W-1:0] FUNC_RESERVED = 3'b011;

endpackage

// File: rtl/alu3_operand_cond.sv
// Conditions the second operand: pass or complement, bit by bit.
module alu3_operand_cond #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] b_raw,
    input  logic              invert,
    output logic [DATA_W-1:0] b_cond
);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign b_cond[gi] = b_raw[gi] ^ invert;
    end

endmodule

// File: rtl/alu3_adder.sv
// Single shared adder; carry-in comes from the function code.
module alu3_adder #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    output logic [DATA_W-1:0] sum
);

    localparam int unsigned PAD_W = DATA_W - 1;

    always_comb begin
        sum = opa + opb + {{PAD_W{1'b0}}, cin};
    end

endmodule

// File: rtl/alu3_out_sel.sv
// Picks the result source and applies the reserved-code rule.
module alu3_out_sel
    import alu3_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [DATA_W-1:0] and_v,
    input  logic [DATA_W-1:0] or_v,
    input  logic [DATA_W-1:0] sum_v,
    output logic [DATA_W-1:0] y
);

    localparam int unsigned MSB   = DATA_W - 1;
    localparam int unsigned PAD_W = DATA_W - 1;

    src_sel_e src;

    always_comb begin
        src = src_sel_e'(func[1:0]);
        y   = '0;
        unique case (src)
            SRC_AND: y = and_v;
            SRC_OR:  y = or_v;
            SRC_SUM: y = sum_v;
            SRC_LT:  y = func[2] ? {{PAD_W{1'b0}}, sum_v[MSB]} : '0;
        endcase
    end

    always_comb begin
        if (src == SRC_LT) begin
            AST_LT_UPPER_CLEAR: assert (y[MSB:1] == '0);            // R7
        end
        if (func == 3'b111) begin
            AST_LT_FOLLOWS_SIGN: assert (y[0] == sum_v[MSB]);        // R7
        end
        if (func == FUNC_RESERVED) begin
            AST_RESERVED_ZERO: assert (y == '0);                     // R8
        end
    end

endmodule

// File: rtl/alu3_core.sv
module alu3_core
    import alu3_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [2:0]        func,
    output logic [DATA_W-1:0] y_out,
    output logic              zero_out
);

    logic [DATA_W-1:0] b_cond;
    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] or_v;
    logic [DATA_W-1:0] sum_v;

    alu3_operand_cond #(.DATA_W(DATA_W)) u_cond (
        .b_raw  (b_in),
        .invert (func[2]),
        .b_cond (b_cond)
    );

    alu3_adder #(.DATA_W(DATA_W)) u_add (
        .opa (a_in),
        .opb (b_cond),
        .cin (func[2]),
        .sum (sum_v)
    );

    always_comb begin
        and_v = a_in & b_cond;
        or_v  = a_in | b_cond;
    end

    alu3_out_sel #(.DATA_W(DATA_W)) u_sel (
        .func  (func),
        .and_v (and_v),
        .or_v  (or_v),
        .sum_v (sum_v),
        .y     (y_out)
    );

    always_comb begin
        zero_out = ~|y_out;
    end

    always_comb begin
        if (func == 3'b000) begin
            AST_AND_WITHIN_A: assert ((y_out & ~a_in) == '0);        // R1
        end
        if (func == 3'b001) begin
            AST_OR_COVERS_A: assert ((y_out & a_in) == a_in);        // R2
        end
        if (func == 3'b110 && a_in == b_in) begin
            AST_SUB_EQUAL_ZERO: assert (zero_out);                   // R6
        end
        if (zero_out) begin
            AST_ZERO_MEANS_EMPTY: assert (y_out == '0);              // R9
        end
    end

endmodule

// File: tb/test_alu3_core.sv
module test_alu3_core;

    localparam int unsigned W      = 32;
    localparam int unsigned NVEC   = 14;
    localparam int unsigned NSWEEP = 400;

    logic         clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [2:0]   func = 3'b000;
    logic [W-1:0] y_out;
    logic         zero_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu3_core #(.DATA_W(W)) i_alu3_core (
        .a_in     (a_in),
        .b_in     (b_in),
        .func     (func),
        .y_out    (y_out),
        .zero_out (zero_out)
    );

    // {func, a, b, expected y, expected zero}
    localparam logic [99:0] VEC [NVEC] = '{
        {3'b000, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0},  // R1
        {3'b001, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 1'b0},  // R2
        {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1},  // R3 wrap
        {3'b010, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 1'b0},  // R3
        {3'b100, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0000, 1'b0},  // R4
        {3'b101, 32'h0000_000F, 32'hFFFF_FF00, 32'h0000_00FF, 1'b0},  // R5
        {3'b110, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0},  // R6
        {3'b110, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 1'b1},  // R6
        {3'b111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0},  // R7
        {3'b111, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1},  // R7
        {3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0},  // R7 overflow
        {3'b111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 1'b1},  // R7 overflow
        {3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},  // R8
        {3'b000, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b1}   // R9
    };

    function automatic logic [W-1:0] model(input logic [2:0] f,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W-1:0] diff;
        diff = a - b;
        case (f)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b100:  return a & ~b;
            3'b101:  return a | ~b;
            3'b110:  return diff;
            3'b111:  return {31'd0, diff[W-1]};
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_y,
                         input logic exp_z);
        checks++;
        if (y_out !== exp_y) begin
            failures++;
            $display("FAIL %s func=%b a=%h b=%h y actual=%h expected=%h",
                     req, func, a_in, b_in, y_out, exp_y);
        end
        checks++;
        if (zero_out !== exp_z) begin
            failures++;
            $display("FAIL R9 (%s) func=%b zero actual=%b expected=%b",
                     req, func, zero_out, exp_z);
        end
    endtask

    task automatic apply(input logic [2:0] f, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(negedge clk);
        func = f;
        a_in = a;
        b_in = b;
        #5;   // same period: no register between ports
    endtask

    initial begin
        logic [W-1:0] lfsr;
        logic [W-1:0] ea;
        logic [W-1:0] eb;
        logic [W-1:0] ey;

        // initial state with all inputs at zero
        apply(3'b000, '0, '0);
        check("R10 initial", '0, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][99:97], VEC[i][96:65], VEC[i][64:33]);
            check("R1-table", VEC[i][32:1], VEC[i][0]);
        end

        // reserved code ignores operands
        apply(3'b011, 32'h8000_0001, 32'h1234_5678);
        check("R8", '0, 1'b1);

        // back-to-back change without any idle period
        apply(3'b010, 32'h0000_0001, 32'h0000_0002);
        check("R10 a", 32'h0000_0003, 1'b0);
        apply(3'b110, 32'h0000_0001, 32'h0000_0002);
        check("R10 b", 32'hFFFF_FFFF, 1'b0);

        lfsr = 32'hACE1_2468;
        for (int n = 0; n < NSWEEP; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            ea   = lfsr;
            eb   = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_0F0F;
            if (n % 16 == 0) eb = ea;
            ey = model(n[2:0], ea, eb);
            apply(n[2:0], ea, eb);
            case (n[2:0])
                3'b000:  check("R1", ey, ey == '0);
                3'b001:  check("R2", ey, ey == '0);
                3'b010:  check("R3", ey, ey == '0);
                3'b011:  check("R8", ey, ey == '0);
                3'b100:  check("R4", ey, ey == '0);
                3'b101:  check("R5", ey, ey == '0);
                3'b110:  check("R6", ey, ey == '0);
                default: check("R7", ey, ey == '0);
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule